// File: doc/BRIEF.md
# AES Byte Substitution Coprocessor

This block is a memory-mapped helper for a soft processor running AES in software. It replaces each byte of a stored value with its AES substitution-box image. The forward table serves encryption and key expansion, and the inverse table serves decryption. Software stores four 32-bit words of cipher state through a simple register bus. It writes a control word that picks the direction and the extent, then sets the go bit. The processor can run other code while the unit works. When it finishes, a done flag rises and, if enabled, an interrupt line follows it. Software then reads the substituted words back from the same locations.

The unit handles one 32-bit word per clock, with four byte lanes working in parallel. A full state takes four cycles. The single-word mode is meant for the key-schedule word substitution and touches only the first word, in one cycle. The table values are computed in logic from the field inverse and the affine map, so no table is stored. A parameter chooses whether both directions share one field-inversion circuit or each direction has its own.

Top module: `byte_subst_cop`

## Requirements
- R1: After reset, all four data words read as zero, the control register reads zero, the status register (0x14) reads zero and irq is low.
- R2: Data words sit at byte offsets 0x00, 0x04, 0x08 and 0x0C, and the control register sits at 0x10. Control bit 1 selects the inverse table, bit 2 selects single-word mode and bit 3 enables the interrupt, and these bits read back as written. Control bit 0 (go) always reads as 0.
- R3: A go with bits 1 and 2 clear replaces every byte of all four words with its forward substitution value, for example 0x00 to 0x63 and 0x53 to 0xED.
- R4: A go with bit 1 set replaces every byte with its inverse substitution value, for example 0x63 to 0x00 and 0xED to 0x53. A forward pass followed by an inverse pass restores the original data.
- R5: A go with bit 2 set substitutes word 0 only and leaves words 1 to 3 unchanged.
- R6: Status bit 0 (busy) is set from the cycle after the go write. In state mode, busy falls and status bit 1 (done) rises four clock cycles after the go write. In single-word mode this happens after one cycle.
- R7: While busy, writes to data or control registers have no effect, and a go issued while busy is dropped without restarting or extending the operation.
- R8: Done is cleared by a bus read of the status register and by a new go. Busy and done are never set together.
- R9: irq is high exactly when done is set and control bit 3 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (side effects only) |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | WORD_W | Write data |
| bus_rdata | output | WORD_W | Read data for bus_addr, combinational |
| irq | output | 1 | Completion interrupt |

## Verification
The hardest conditions to reach are bus traffic that arrives while the unit is busy, and a status read that lands exactly as the unit finishes. The bench drives bus strobes on falling edges and counts clock edges from the go write. This lets it place a data write, a control write and a second go inside the four-cycle busy window. Status is also sampled by address alone, without the read strobe, in the cycles just before and after done. This observes the completion edge without clearing the flag.

// File: rtl/sbx_pkg.sv
package sbx_pkg;

   localparam int CB_GO  = 0;
   localparam int CB_INV = 1;
   localparam int CB_ONE = 2;
   localparam int CB_IEN = 3;
   localparam int SB_BUSY = 0;
   localparam int SB_DONE = 1;

   localparam logic [7:0] AFF_C  = 8'h63;
   localparam logic [7:0] AFF_IC = 8'h05;
   localparam logic [7:0] POLY_R = 8'h1B;

   function automatic logic [7:0] rotl8(input logic [7:0] v, input int n);
      logic [15:0] d;
      d = {v, v} << n;
      return d[15:8];
   endfunction

   function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
      logic [7:0] acc;
      logic [7:0] sh;
      acc = 8'h00;
      sh  = a;
      for (int i = 0; i < 8; i++) begin
         if (b[i]) acc = acc ^ sh;
         sh = {sh[6:0], 1'b0} ^ (sh[7] ? POLY_R : 8'h00);
      end
      return acc;
   endfunction

   // a^254 is the field inverse, and 0 maps to 0
   function automatic logic [7:0] gf_inv(input logic [7:0] a);
      logic [7:0] p;
      p = a;
      for (int i = 0; i < 6; i++) begin
         p = gf_mul(gf_mul(p, p), a);
      end
      return gf_mul(p, p);
   endfunction

   function automatic logic [7:0] aff_fwd(input logic [7:0] v);
      return v ^ rotl8(v, 1) ^ rotl8(v, 2) ^ rotl8(v, 3) ^ rotl8(v, 4) ^ AFF_C;
   endfunction

   function automatic logic [7:0] aff_inv(input logic [7:0] v);
      return rotl8(v, 1) ^ rotl8(v, 3) ^ rotl8(v, 6) ^ AFF_IC;
   endfunction

endpackage

// File: rtl/sbx_lane.sv
module sbx_lane
   import sbx_pkg::*;
#(
   parameter bit SHARED_INV = 1'b1
) (
   input  logic [7:0] x_i,
   input  logic       inv_i,
   output logic [7:0] y_o
);

   generate
      if (SHARED_INV) begin : g_shared
         logic [7:0] pre;
         logic [7:0] fi;
         always_comb begin
            pre = inv_i ? aff_inv(x_i) : x_i;
            fi  = gf_inv(pre);
            y_o = inv_i ? fi : aff_fwd(fi);
         end
      end else begin : g_split
         logic [7:0] fwd;
         logic [7:0] bwd;
         always_comb begin
            fwd = aff_fwd(gf_inv(x_i));
            bwd = gf_inv(aff_inv(x_i));
            y_o = inv_i ? bwd : fwd;
         end
      end
   endgenerate

endmodule

// File: rtl/sbx_word.sv
module sbx_word #(
   parameter int  WORD_W     = 32,
   parameter bit  SHARED_INV = 1'b1
) (
   input  logic [WORD_W-1:0] w_i,
   input  logic              inv_i,
   output logic [WORD_W-1:0] w_o
);
   localparam int LANES = WORD_W / 8;

   generate
      if (WORD_W % 8 != 0 || WORD_W < 8) begin : g_bad_w
         $error("sbx_word: WORD_W must be a positive multiple of 8");
      end
      for (genvar l = 0; l < LANES; l++) begin : g_lane
         sbx_lane #(.SHARED_INV(SHARED_INV)) u_lane (
            .x_i  (w_i[8*l +: 8]),
            .inv_i(inv_i),
            .y_o  (w_o[8*l +: 8])
         );
      end
   endgenerate

endmodule

// File: rtl/sbx_seq.sv
module sbx_seq #(
   parameter int NUM_WORDS = 4,
   parameter int IDX_W     = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             go_i,
   input  logic             one_i,
   input  logic             clr_i,
   output logic             busy_o,
   output logic             done_o,
   output logic [IDX_W-1:0] idx_o
);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_WORDS - 1);

   logic last;
   assign last = one_i || (idx_o == LAST_IDX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_o <= 1'b0;
         done_o <= 1'b0;
         idx_o  <= '0;
      end else if (busy_o) begin
         if (last) begin
            busy_o <= 1'b0;
            done_o <= 1'b1;
            idx_o  <= '0;
         end else begin
            idx_o <= idx_o + 1'b1;
         end
      end else if (go_i) begin
         busy_o <= 1'b1;
         done_o <= 1'b0;
         idx_o  <= '0;
      end else if (clr_i) begin
         done_o <= 1'b0;
      end
   end

endmodule

// File: rtl/byte_subst_cop.sv
module byte_subst_cop
   import sbx_pkg::*;
#(
   parameter int WORD_W     = 32,
   parameter int NUM_WORDS  = 4,
   parameter int ADDR_W     = 5,
   parameter bit SHARED_INV = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [WORD_W-1:0] bus_wdata,
   output logic [WORD_W-1:0] bus_rdata,
   output logic              irq
);
   localparam int IDX_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;
   localparam int SLOT_W   = ADDR_W - 2;
   localparam int CTRL_IDX = NUM_WORDS;
   localparam int STAT_IDX = NUM_WORDS + 1;

   generate
      if (NUM_WORDS < 1) begin : g_bad_n
         $error("byte_subst_cop: NUM_WORDS must be at least 1");
      end
      if ((1 << SLOT_W) < NUM_WORDS + 2) begin : g_bad_a
         $error("byte_subst_cop: ADDR_W too small for the register map");
      end
      if (WORD_W < 4) begin : g_bad_w
         $error("byte_subst_cop: WORD_W too small for control bits");
      end
   endgenerate

   logic [SLOT_W-1:0] slot;
   logic              aligned;
   logic              sel_ctrl;
   logic              sel_stat;
   assign slot     = bus_addr[ADDR_W-1:2];
   assign aligned  = (bus_addr[1:0] == 2'b00);
   assign sel_ctrl = aligned && (slot == SLOT_W'(CTRL_IDX));
   assign sel_stat = aligned && (slot == SLOT_W'(STAT_IDX));

   logic busy, done;
   logic [IDX_W-1:0] idx;
   logic inv_q, one_q, ien_q;
   logic go;
   logic stat_rd;

   assign go      = bus_wr && sel_ctrl && bus_wdata[CB_GO] && !busy;
   assign stat_rd = bus_rd && sel_stat;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         inv_q <= 1'b0;
         one_q <= 1'b0;
         ien_q <= 1'b0;
      end else if (bus_wr && sel_ctrl && !busy) begin
         inv_q <= bus_wdata[CB_INV];
         one_q <= bus_wdata[CB_ONE];
         ien_q <= bus_wdata[CB_IEN];
      end
   end

   sbx_seq #(.NUM_WORDS(NUM_WORDS), .IDX_W(IDX_W)) u_seq (
      .clk   (clk),
      .rst_n (rst_n),
      .go_i  (go),
      .one_i (one_q),
      .clr_i (stat_rd),
      .busy_o(busy),
      .done_o(done),
      .idx_o (idx)
   );

   logic [WORD_W-1:0] data_q [NUM_WORDS];
   logic [WORD_W-1:0] sub_in;
   logic [WORD_W-1:0] sub_out;

   always_comb begin
      sub_in = data_q[0];
      for (int i = 0; i < NUM_WORDS; i++) begin
         if (idx == IDX_W'(i)) sub_in = data_q[i];
      end
   end

   sbx_word #(.WORD_W(WORD_W), .SHARED_INV(SHARED_INV)) u_word (
      .w_i  (sub_in),
      .inv_i(inv_q),
      .w_o  (sub_out)
   );

   generate
      for (genvar w = 0; w < NUM_WORDS; w++) begin : g_data
         logic hit;
         assign hit = aligned && (slot == SLOT_W'(w));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               data_q[w] <= '0;
            end else if (busy) begin
               if (idx == IDX_W'(w)) data_q[w] <= sub_out;
            end else if (bus_wr && hit) begin
               data_q[w] <= bus_wdata;
            end
         end
      end
   endgenerate

   always_comb begin
      bus_rdata = '0;
      if (sel_ctrl) begin
         bus_rdata[CB_INV] = inv_q;
         bus_rdata[CB_ONE] = one_q;
         bus_rdata[CB_IEN] = ien_q;
      end else if (sel_stat) begin
         bus_rdata[SB_BUSY] = busy;
         bus_rdata[SB_DONE] = done;
      end else begin
         for (int i = 0; i < NUM_WORDS; i++) begin
            if (aligned && slot == SLOT_W'(i)) bus_rdata = data_q[i];
         end
      end
   end

   assign irq = done && ien_q;

endmodule

// File: rtl/sbx_chk.sv
module sbx_chk #(
   parameter int ADDR_W    = 5,
   parameter int NUM_WORDS = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_wr,
   input logic              bus_rd,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              go_bit,
   input logic              busy,
   input logic              done,
   input logic              irq,
   input logic              ien,
   input logic              inv_mode,
   input logic              one_mode
);
   localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(4 * NUM_WORDS);
   localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(4 * NUM_WORDS + 4);

   int busy_run;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) busy_run <= 0;
      else if (busy) busy_run <= busy_run + 1;
      else busy_run <= 0;
   end

   // R8
   busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(busy && done));

   // R6
   busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (busy_run < NUM_WORDS));

   // R6
   end_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);

   // R6
   start_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(bus_wr && bus_addr == CTRL_A && go_bit));

   // R7
   mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> ($stable(inv_mode) && $stable(one_mode) && $stable(ien)));

   // R8
   stat_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr == STAT_A && !busy) |=> !done);

   // R9
   irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(done) && ien) |-> irq);

   // R9
   irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (done && !busy));

endmodule

bind byte_subst_cop sbx_chk #(.ADDR_W(ADDR_W), .NUM_WORDS(NUM_WORDS)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .bus_wr  (bus_wr),
   .bus_rd  (bus_rd),
   .bus_addr(bus_addr),
   .go_bit  (bus_wdata[0]),
   .busy    (busy),
   .done    (done),
   .irq     (irq),
   .ien     (ien_q),
   .inv_mode(inv_q),
   .one_mode(one_q)
);

// File: tb/tb_byte_subst_cop.sv
module tb_byte_subst_cop;
   localparam int AW = 5;
   localparam logic [AW-1:0] A_CTRL = 5'h10;
   localparam logic [AW-1:0] A_STAT = 5'h14;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bus_wr = 1'b0, bus_rd = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic irq;

   always #2 clk = ~clk;

   byte_subst_cop dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
   );

   int n_tests = 0;
   int n_fail = 0;
   logic [7:0] fsb [256];
   logic [7:0] isb [256];

   // {single, inverse, word3, word2, word1, word0}
   localparam logic [129:0] VEC [6] = '{
      {2'b00, 32'h00000000, 32'h00000000, 32'h00000000, 32'h00000000},
      {2'b00, 32'h53535353, 32'h0F0E0D0C, 32'hFF80017F, 32'h00010203},
      {2'b01, 32'hEDEDEDED, 32'h63636363, 32'h16BB54B0, 32'h7C777BF2},
      {2'b10, 32'h11223344, 32'h55667788, 32'h99AABBCC, 32'h0053A5FF},
      {2'b11, 32'hDEADBEEF, 32'hCAFEF00D, 32'h12345678, 32'h63ED7C52},
      {2'b00, 32'hFFFFFFFF, 32'hC0C1C2C3, 32'h3A4B5C6D, 32'h89ABCDEF}
   };

   function automatic logic [7:0] rl(input logic [7:0] v, input int n);
      logic [15:0] d;
      d = {v, v} << n;
      return d[15:8];
   endfunction

   task automatic build_tables();
      logic [7:0] p, q, t, x;
      p = 8'h01; q = 8'h01;
      do begin
         t = p;
         p = t ^ {t[6:0], 1'b0} ^ (t[7] ? 8'h1B : 8'h00);
         q = q ^ {q[6:0], 1'b0};
         q = q ^ {q[5:0], 2'b00};
         q = q ^ {q[3:0], 4'b0000};
         if (q[7]) q = q ^ 8'h09;
         x = q ^ rl(q, 1) ^ rl(q, 2) ^ rl(q, 3) ^ rl(q, 4);
         fsb[p] = x ^ 8'h63;
      end while (p != 8'h01);
      fsb[0] = 8'h63;
      for (int i = 0; i < 256; i++) isb[fsb[i]] = 8'(i);
   endtask

   function automatic logic [31:0] mdl(input logic [31:0] w, input logic inv);
      logic [31:0] r;
      for (int b = 0; b < 4; b++) r[8*b +: 8] = inv ? isb[w[8*b +: 8]] : fsb[w[8*b +: 8]];
      return r;
   endfunction

   task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = a;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic peek(input logic [AW-1:0] a, output logic [31:0] d);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic wait_done();
      logic [31:0] s;
      for (int k = 0; k < 12; k++) begin
         peek(A_STAT, s);
         if (s[1]) break;
         @(negedge clk);
      end
   endtask

   task automatic load(input logic [127:0] d);
      for (int i = 0; i < 4; i++) wr(AW'(4 * i), d[32*i +: 32]);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin : main
      logic [31:0] v, s;
      logic [127:0] orig;
      build_tables();
      repeat (4) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      for (int i = 0; i < 4; i++) begin
         rd(AW'(4 * i), v);
         check("R1", "data after reset", v, 32'h0);
      end
      rd(A_CTRL, v); check("R1", "ctrl after reset", v, 32'h0);
      rd(A_STAT, v); check("R1", "status after reset", v, 32'h0);
      check("R1", "irq after reset", {31'b0, irq}, 32'h0);

      // R2 register access
      wr(A_CTRL, 32'h0000000E);
      rd(A_CTRL, v); check("R2", "ctrl readback", v, 32'h0000000E);
      wr(A_CTRL, 32'h0);
      load({32'hA5A5A5A5, 32'h01234567, 32'h89ABCDEF, 32'hFEDCBA98});
      rd(5'h08, v); check("R2", "data word2 readback", v, 32'h01234567);
      rd(5'h0C, v); check("R2", "data word3 readback", v, 32'hA5A5A5A5);

      // vector table: R3 forward, R4 inverse, R5 single word
      for (int n = 0; n < 6; n++) begin
         logic one, inv;
         logic [31:0] exp;
         one = VEC[n][129]; inv = VEC[n][128];
         load(VEC[n][127:0]);
         wr(A_CTRL, {29'b0, one, inv, 1'b1});
         wait_done();
         for (int i = 0; i < 4; i++) begin
            rd(AW'(4 * i), v);
            if (one && i != 0) exp = VEC[n][32*i +: 32];
            else exp = mdl(VEC[n][32*i +: 32], inv);
            check(one ? "R5" : (inv ? "R4" : "R3"), "vector word", v, exp);
         end
         rd(A_STAT, v);
      end

      // R3 known points
      load({32'h0, 32'h0, 32'h0, 32'h00530053});
      wr(A_CTRL, 32'h1); wait_done();
      rd(5'h00, v); check("R3", "0x00->0x63 0x53->0xED", v, 32'h63ED63ED);
      // R4 known points
      load({32'h0, 32'h0, 32'h0, 32'h63ED63ED});
      wr(A_CTRL, 32'h3); wait_done();
      rd(5'h00, v); check("R4", "0x63->0x00 0xED->0x53", v, 32'h00530053);

      // R4 round trip
      orig = {32'h3C4D5E6F, 32'h708192A3, 32'hB4C5D6E7, 32'hF8091A2B};
      load(orig);
      wr(A_CTRL, 32'h1); wait_done();
      wr(A_CTRL, 32'h3); wait_done();
      for (int i = 0; i < 4; i++) begin
         rd(AW'(4 * i), v); check("R4", "round trip", v, orig[32*i +: 32]);
      end

      // R6 timing in state mode
      rd(A_STAT, v);
      wr(A_CTRL, 32'h1);
      peek(A_STAT, s); check("R6", "busy after go", s, 32'h1);
      repeat (3) @(negedge clk);
      peek(A_STAT, s); check("R6", "busy at cycle 3", s, 32'h1);
      @(negedge clk);
      peek(A_STAT, s); check("R6", "done at cycle 4", s, 32'h2);

      // R6 timing in single-word mode
      wr(A_CTRL, 32'h5);
      peek(A_STAT, s); check("R6", "single busy after go", s, 32'h1);
      @(negedge clk);
      peek(A_STAT, s); check("R6", "single done at cycle 1", s, 32'h2);

      // R8 status read clears done
      rd(A_STAT, v); check("R8", "status read value", v, 32'h2);
      peek(A_STAT, s); check("R8", "done cleared by read", s, 32'h0);

      // R7 writes and go while busy are ignored
      orig = {32'h10203040, 32'h50607080, 32'h90A0B0C0, 32'hD0E0F000};
      load(orig);
      wr(A_CTRL, 32'h1);
      wr(5'h0C, 32'hFFFFFFFF);
      wr(A_CTRL, 32'h0000000F);
      peek(A_STAT, s); check("R7", "no restart from go while busy", s, 32'h2);
      rd(A_CTRL, v); check("R7", "ctrl unchanged", v, 32'h0);
      rd(5'h0C, v); check("R7", "data write ignored", v, mdl(orig[127:96], 1'b0));
      rd(5'h00, v); check("R7", "word0 substituted", v, mdl(orig[31:0], 1'b0));

      // R8 new go clears done
      wr(A_CTRL, 32'h5);
      wait_done();
      wr(A_CTRL, 32'h1);
      peek(A_STAT, s); check("R8", "done cleared by new go", s, 32'h1);
      wait_done();

      // R9 interrupt follows done when enabled
      check("R9", "irq low with enable clear", {31'b0, irq}, 32'h0);
      rd(A_STAT, v);
      wr(A_CTRL, 32'h9);
      wait_done();
      #1 check("R9", "irq high on done", {31'b0, irq}, 32'h1);
      rd(A_STAT, v);
      #1 check("R9", "irq low after status read", {31'b0, irq}, 32'h0);

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule